// File: doc/BRIEF.md
# DRAM Row/Column Strobe Sequencer

This block drives the active-low row strobe (`ras_n`) and column strobe (`cas_n`) of one DRAM bank. It runs on a clock at twice the system clock rate, so every interval it produces is a whole number of ticks, and one tick is half a system clock. A request is taken when `req` and `ready` are both high. The block then runs one of four cycles, chosen by `req_kind`: a single transfer, the first access of a page-mode burst (the page is left open), a page close, or a CAS-before-RAS refresh. `done` pulses for one tick at the end of each cycle.

Two 2-bit codes set the timing. `ras_hold_code` sets how long the row strobe stays low once the column strobe has asserted. `prech_code` sets how long the row strobe stays high before another row may open. When `edo_en` is set, the hold time of a page-mode first access is half a clock shorter. Code 3 in either field is reserved. It raises `cfg_err`, and the block then uses the longest legal timing. The codes are sampled when a request is accepted.

States: `S_IDLE` (no row open, ready), `S_ROW` (row strobe low, column setup), `S_COL` (both strobes low), `S_CBR_CAS` (column strobe alone, refresh lead), `S_CBR_BOTH` (both low during refresh), `S_OPEN` (page open, ready), `S_PRECH` (both high, precharge). Transitions: IDLE→ROW on a single or page request; IDLE→CBR_CAS on refresh; IDLE→PRECH on a page close; OPEN→PRECH on any request; ROW→COL after the setup count; COL→PRECH (single) or COL→OPEN (page) after the hold count; CBR_CAS→CBR_BOTH after one tick; CBR_BOTH→PRECH after the hold count; PRECH→IDLE after the precharge count.

Top module: `dram_strobe_seq`

## Requirements
- R1: After reset, and also while reset is held, `ras_n`=1, `cas_n`=1, `ready`=1 and `done`=0. An asynchronous reset in the middle of a cycle returns both strobes high at once.
- R2: For a single transfer (`req_kind`=0), the row strobe falls first. The column strobe falls 2 ticks later. Both then stay low together for 3, 5 or 7 ticks for hold codes 0, 1 or 2, and both rise on the same tick. `edo_en` has no effect on this cycle.
- R3: For a page-mode first access (`req_kind`=1), the row setup is 2 ticks. With `edo_en`=0 the column strobe is low for 3, 5 or 7 ticks (hold codes 0, 1, 2). With `edo_en`=1 it is low for 2, 4 or 6 ticks. After that the column strobe rises, the row strobe stays low (page open) and `ready` returns high.
- R4: The precharge interval keeps both strobes high with `ready` low for 3, 5 or 7 ticks (precharge codes 0, 1, 2). It follows every single transfer, every refresh and every page close.
- R5: For a refresh (`req_kind`=3), the column strobe falls one tick before the row strobe. Both then stay low for the single-transfer hold time (3, 5 or 7 ticks, whatever the value of `edo_en`), and then precharge follows.
- R6: A code of 3 in either field drives `cfg_err` high combinationally from the inputs. The cycle then uses 7 ticks for that interval, whether or not EDO is enabled.
- R7: A request made while `ready` is low is held off. If `req` stays high, the next row strobe falls exactly one tick after precharge ends, so the row strobe is high for the precharge count plus 1 tick.
- R8: Timing codes are captured when a request is accepted. Changing them during the cycle does not alter that cycle's hold or precharge length.
- R9: While the page is open, any request closes it. The row strobe rises on the next tick and precharge follows with the live precharge code. A page close (`req_kind`=2) issued while idle runs only the precharge, and no strobe falls.
- R10: `done` is high for exactly one tick per accepted request. That tick is the last tick of the precharge, or the last column tick of a page-mode first access. `ready` is high on the tick after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock, twice the system clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Request, accepted when `ready` is high |
| req_kind | input | 2 | 0 single, 1 page first access, 2 page close, 3 refresh |
| edo_en | input | 1 | Shortens the page-mode first-access hold by one tick |
| ras_hold_code | input | 2 | Row hold after column assert: 0/1/2 = 1.5/2.5/3.5 clocks, 3 reserved |
| prech_code | input | 2 | Precharge: 0/1/2 = 1.5/2.5/3.5 clocks, 3 reserved |
| ready | output | 1 | High in idle or page-open state |
| done | output | 1 | One-tick end-of-cycle pulse |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| cfg_err | output | 1 | A reserved code is present on the inputs |

## Verification
A table of requests runs every cycle kind under each hold and precharge code, with EDO both on and off and with the reserved codes. For each request the bench counts, tick by tick, how long the strobes stay in each combination of levels. From those counts it can tell a normal hold from a shortened EDO hold, CAS-first refresh ordering from row-first ordering, and an open page from a closed one. Directed cases then hold `req` high through precharge, change the codes during a cycle, close a page with a request of another kind, close when idle, and reset in the middle of a cycle. Each of these separates latched timing, hold-off and close behaviour from the plain path.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

    typedef enum logic [1:0] {
        REQ_SINGLE = 2'd0,
        REQ_PAGE   = 2'd1,
        REQ_CLOSE  = 2'd2,
        REQ_CBR    = 2'd3
    } req_kind_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ROW,
        S_COL,
        S_CBR_CAS,
        S_CBR_BOTH,
        S_OPEN,
        S_PRECH
    } seq_state_e;

endpackage

// File: rtl/dram_seq_decode.sv
module dram_seq_decode #(
    parameter int CNT_W      = 3,
    parameter int BASE_TICKS = 3,
    parameter int LONG_TICKS = 7
) (
    input  logic [1:0]       hold_code,
    input  logic [1:0]       prech_code,
    input  logic             shorten,
    output logic [CNT_W-1:0] hold_ticks,
    output logic [CNT_W-1:0] prech_ticks,
    output logic             reserved
);

    // Each code step adds one full system clock (two ticks).
    always_comb begin
        if (hold_code == 2'b11)
            hold_ticks = CNT_W'(LONG_TICKS);
        else
            hold_ticks = CNT_W'(BASE_TICKS + 2 * int'(hold_code) - int'(shorten));

        if (prech_code == 2'b11)
            prech_ticks = CNT_W'(LONG_TICKS);
        else
            prech_ticks = CNT_W'(BASE_TICKS + 2 * int'(prech_code));

        reserved = (hold_code == 2'b11) || (prech_code == 2'b11);
    end

endmodule

// File: rtl/dram_seq_counter.sv
module dram_seq_counter #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);

    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - W'(1);
    end

    assign zero = (cnt == '0);

endmodule

// File: rtl/dram_strobe_seq.sv
module dram_strobe_seq
    import dram_seq_pkg::*;
#(
    parameter int CNT_W       = 3,
    parameter int SETUP_TICKS = 2,
    parameter int LEAD_TICKS  = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req,
    input  logic [1:0] req_kind,
    input  logic       edo_en,
    input  logic [1:0] ras_hold_code,
    input  logic [1:0] prech_code,
    output logic       ready,
    output logic       done,
    output logic       ras_n,
    output logic       cas_n,
    output logic       cfg_err
);

    localparam logic [CNT_W-1:0] ONE       = CNT_W'(1);
    localparam logic [CNT_W-1:0] SETUP_VAL = CNT_W'(SETUP_TICKS - 1);
    localparam logic [CNT_W-1:0] LEAD_VAL  = CNT_W'(LEAD_TICKS - 1);

    seq_state_e       state, next_state;
    req_kind_e        kind_live, kind_q;
    logic             accept, cnt_zero, cnt_load, shorten;
    logic [CNT_W-1:0] dec_hold, dec_prech, hold_q, prech_q, load_val, prech_src;

    assign kind_live = req_kind_e'(req_kind);
    assign shorten   = edo_en && (kind_live == REQ_PAGE);
    assign accept    = req && ready;

    dram_seq_decode #(.CNT_W(CNT_W)) i_decode (
        .hold_code   (ras_hold_code),
        .prech_code  (prech_code),
        .shorten     (shorten),
        .hold_ticks  (dec_hold),
        .prech_ticks (dec_prech),
        .reserved    (cfg_err)
    );

    dram_seq_counter #(.W(CNT_W)) i_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (load_val),
        .zero     (cnt_zero)
    );

    // Timing captured at acceptance
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind_q  <= REQ_SINGLE;
            hold_q  <= '0;
            prech_q <= '0;
        end else if (accept) begin
            kind_q  <= kind_live;
            hold_q  <= dec_hold;
            prech_q <= dec_prech;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= S_IDLE;
        else
            state <= next_state;
    end

    // Transitions
    always_comb begin
        next_state = state;
        unique case (state)
            S_IDLE: begin
                if (req) begin
                    unique case (kind_live)
                        REQ_SINGLE, REQ_PAGE: next_state = S_ROW;
                        REQ_CLOSE:            next_state = S_PRECH;
                        REQ_CBR:              next_state = S_CBR_CAS;
                        default:              next_state = S_IDLE;
                    endcase
                end
            end
            S_OPEN:     if (req)      next_state = S_PRECH;
            S_ROW:      if (cnt_zero) next_state = S_COL;
            S_COL:      if (cnt_zero) next_state = (kind_q == REQ_PAGE) ? S_OPEN : S_PRECH;
            S_CBR_CAS:  if (cnt_zero) next_state = S_CBR_BOTH;
            S_CBR_BOTH: if (cnt_zero) next_state = S_PRECH;
            S_PRECH:    if (cnt_zero) next_state = S_IDLE;
            default:                  next_state = S_IDLE;
        endcase
    end

    // Counter reload on every state change
    assign prech_src = ready ? dec_prech : prech_q;
    assign cnt_load  = (next_state != state);

    always_comb begin
        unique case (next_state)
            S_ROW:              load_val = SETUP_VAL;
            S_COL, S_CBR_BOTH:  load_val = hold_q - ONE;
            S_CBR_CAS:          load_val = LEAD_VAL;
            S_PRECH:            load_val = prech_src - ONE;
            default:            load_val = '0;
        endcase
    end

    // Outputs
    always_comb begin
        ras_n = 1'b1;
        cas_n = 1'b1;
        ready = 1'b0;
        done  = 1'b0;
        unique case (state)
            S_IDLE:     ready = 1'b1;
            S_ROW:      ras_n = 1'b0;
            S_COL: begin
                ras_n = 1'b0;
                cas_n = 1'b0;
                done  = cnt_zero && (kind_q == REQ_PAGE);
            end
            S_CBR_CAS:  cas_n = 1'b0;
            S_CBR_BOTH: begin
                ras_n = 1'b0;
                cas_n = 1'b0;
            end
            S_OPEN: begin
                ras_n = 1'b0;
                ready = 1'b1;
            end
            S_PRECH:    done = cnt_zero;
            default:    ready = 1'b0;
        endcase
    end

endmodule

// File: rtl/dram_strobe_seq_chk.sv
module dram_strobe_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic ready,
    input logic done,
    input logic ras_n,
    input logic cas_n
);

    // R2: column strobe falls after exactly two ticks of row setup
    p_col_after_row_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cas_n) && !ras_n) |-> (!$past(ras_n) && !$past(ras_n, 2) && $past(ras_n, 3)));

    // R5: refresh column strobe leads the row strobe by one tick
    p_cbr_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ras_n) && !cas_n) |-> (!$past(cas_n) && $past(cas_n, 2)));

    // R5: column strobe alone lasts a single tick
    p_cas_alone_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!cas_n && ras_n) |=> !ras_n);

    // R4: a row never opens with less than three ticks of precharge
    p_prech_min_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> ($past(ras_n) && $past(ras_n, 2) && $past(ras_n, 3)));

    // R7: the block is busy while a row closes
    p_busy_on_close_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n) |-> !ready);

    // R10: done lasts one tick and is followed by ready
    p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (ready && !done));

endmodule

bind dram_strobe_seq dram_strobe_seq_chk i_chk (.*);

// File: tb/test_dram_strobe_seq.sv
module test_dram_strobe_seq;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       req;
    logic [1:0] req_kind;
    logic       edo_en;
    logic [1:0] ras_hold_code;
    logic [1:0] prech_code;
    logic       ready, done, ras_n, cas_n, cfg_err;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    dram_strobe_seq i_dram_strobe_seq (
        .clk(clk), .rst_n(rst_n), .req(req), .req_kind(req_kind), .edo_en(edo_en),
        .ras_hold_code(ras_hold_code), .prech_code(prech_code), .ready(ready),
        .done(done), .ras_n(ras_n), .cas_n(cas_n), .cfg_err(cfg_err)
    );

    // {kind[13:12], edo[11], hold[10:9], prech[8:7], exp_hold[6:4], exp_prech[3:1], exp_err[0]}
    localparam logic [13:0] VEC [0:10] = '{
        {2'd0, 1'b0, 2'd0, 2'd0, 3'd3, 3'd3, 1'b0},
        {2'd0, 1'b1, 2'd1, 2'd2, 3'd5, 3'd7, 1'b0},
        {2'd0, 1'b0, 2'd2, 2'd1, 3'd7, 3'd5, 1'b0},
        {2'd1, 1'b0, 2'd1, 2'd0, 3'd5, 3'd3, 1'b0},
        {2'd1, 1'b1, 2'd0, 2'd1, 3'd2, 3'd5, 1'b0},
        {2'd1, 1'b1, 2'd2, 2'd0, 3'd6, 3'd3, 1'b0},
        {2'd1, 1'b1, 2'd3, 2'd3, 3'd7, 3'd7, 1'b1},
        {2'd3, 1'b1, 2'd0, 2'd2, 3'd3, 3'd7, 1'b0},
        {2'd3, 1'b0, 2'd1, 2'd0, 3'd5, 3'd3, 1'b0},
        {2'd0, 1'b0, 2'd3, 2'd1, 3'd7, 3'd5, 1'b1},
        {2'd0, 1'b1, 2'd0, 2'd3, 3'd3, 3'd7, 1'b1}
    };

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Issue one request and count ticks spent in each strobe combination.
    task automatic run_req(input logic [1:0] k, input logic e, input logic [1:0] h,
                           input logic [1:0] p, input bit change,
                           output int row, output int cbr, output int both,
                           output int prc, output int dn, output int ras_end,
                           output int err);
        @(negedge clk);
        req_kind = k; edo_en = e; ras_hold_code = h; prech_code = p; req = 1'b1;
        #1 err = int'(cfg_err);
        @(negedge clk);
        req = 1'b0;
        if (change) begin
            ras_hold_code = 2'd2;
            prech_code    = 2'd2;
        end
        row = 0; cbr = 0; both = 0; prc = 0; dn = 0;
        for (int i = 0; i < 40; i++) begin
            if (ready) break;
            if (!ras_n && cas_n)       row++;
            else if (ras_n && !cas_n)  cbr++;
            else if (!ras_n && !cas_n) both++;
            else                       prc++;
            if (done) dn++;
            @(negedge clk);
        end
        ras_end = int'(ras_n);
    endtask

    initial begin
        #(200000 * 8);
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int row, cbr, both, prc, dn, rend, err;
        rst_n = 1'b0; req = 1'b0; req_kind = 2'd0; edo_en = 1'b0;
        ras_hold_code = 2'd0; prech_code = 2'd0;
        repeat (4) @(negedge clk);
        chk("R1 ras_n in reset", int'(ras_n), 1);
        chk("R1 cas_n in reset", int'(cas_n), 1);
        chk("R1 ready in reset", int'(ready), 1);
        chk("R1 done in reset", int'(done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ready after reset", int'(ready), 1);
        chk("R6 cfg_err legal codes", int'(cfg_err), 0);

        // Table of requests
        for (int v = 0; v < 11; v++) begin
            logic [1:0] k, h, p;
            logic       e, xerr;
            int         xh, xp;
            k = VEC[v][13:12]; e = VEC[v][11]; h = VEC[v][10:9]; p = VEC[v][8:7];
            xh = int'(VEC[v][6:4]); xp = int'(VEC[v][3:1]); xerr = VEC[v][0];
            run_req(k, e, h, p, 1'b0, row, cbr, both, prc, dn, rend, err);
            chk("R6 cfg_err", err, int'(xerr));
            chk("R10 done count", dn, 1);
            if (k == 2'd0) begin
                chk("R2 row setup ticks", row, 2);
                chk("R2 both-low ticks", both, xh);
                chk("R4 precharge after single", prc, xp);
                chk("R2 ras_n at end", rend, 1);
            end else if (k == 2'd1) begin
                chk("R3 row setup ticks", row, 2);
                chk("R3 column ticks", both, xh);
                chk("R3 no precharge while open", prc, 0);
                chk("R3 page stays open", rend, 0);
                run_req(2'd2, e, h, p, 1'b0, row, cbr, both, prc, dn, rend, err);
                chk("R4 precharge after close", prc, xp);
                chk("R9 no strobe on close", row + both + cbr, 0);
                chk("R10 done count close", dn, 1);
                chk("R9 ras_n high after close", rend, 1);
            end else begin
                chk("R5 cas lead ticks", cbr, 1);
                chk("R5 refresh both-low ticks", both, xh);
                chk("R5 no row-first tick", row, 0);
                chk("R4 precharge after refresh", prc, xp);
            end
        end

        // R7: request held through precharge
        begin
            int  hi, hi_busy;
            bit  seen_low, in_gap;
            hi = 0; hi_busy = 0; seen_low = 0; in_gap = 0;
            @(negedge clk);
            req_kind = 2'd0; edo_en = 1'b0; ras_hold_code = 2'd0; prech_code = 2'd0;
            req = 1'b1;
            for (int i = 0; i < 60; i++) begin
                @(negedge clk);
                if (!ras_n && in_gap) break;
                if (!ras_n) seen_low = 1;
                else if (seen_low) begin
                    in_gap = 1;
                    hi++;
                    if (!ready) hi_busy++;
                end
            end
            req = 1'b0;
            chk("R7 row high ticks between held requests", hi, 4);
            chk("R7 ready low during precharge", hi_busy, 3);
            for (int i = 0; i < 40; i++) begin
                if (ready) break;
                @(negedge clk);
            end
        end

        // R8: codes changed after acceptance
        run_req(2'd0, 1'b0, 2'd0, 2'd0, 1'b1, row, cbr, both, prc, dn, rend, err);
        chk("R8 hold unchanged by late code", both, 3);
        chk("R8 precharge unchanged by late code", prc, 3);

        // R9: close while idle
        run_req(2'd2, 1'b0, 2'd0, 2'd1, 1'b0, row, cbr, both, prc, dn, rend, err);
        chk("R9 idle close precharge", prc, 5);
        chk("R9 idle close no strobe", row + cbr + both, 0);

        // R9: refresh-kind request while page open closes it
        run_req(2'd1, 1'b0, 2'd0, 2'd0, 1'b0, row, cbr, both, prc, dn, rend, err);
        chk("R3 page open before foreign request", rend, 0);
        run_req(2'd3, 1'b0, 2'd0, 2'd2, 1'b0, row, cbr, both, prc, dn, rend, err);
        chk("R9 foreign request closes page", prc, 7);
        chk("R9 foreign request no refresh", cbr + both, 0);

        // R6: reserved codes on each field
        @(negedge clk);
        ras_hold_code = 2'd3; prech_code = 2'd0;
        #1 chk("R6 cfg_err reserved hold", int'(cfg_err), 1);
        prech_code = 2'd3; ras_hold_code = 2'd1;
        #1 chk("R6 cfg_err reserved precharge", int'(cfg_err), 1);
        prech_code = 2'd2;
        #1 chk("R6 cfg_err cleared", int'(cfg_err), 0);

        // R1: reset in the middle of a cycle
        @(negedge clk);
        req_kind = 2'd0; ras_hold_code = 2'd2; prech_code = 2'd2; req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 row low before mid reset", int'(ras_n), 0);
        rst_n = 1'b0;
        #1;
        chk("R1 ras_n on mid reset", int'(ras_n), 1);
        chk("R1 cas_n on mid reset", int'(cas_n), 1);
        chk("R1 ready on mid reset", int'(ready), 1);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle after mid reset", int'(ras_n & cas_n & ready), 1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule